// File: doc/BRIEF.md
# Auxiliary External Interrupt Collector

The block gathers interrupt requests from two external active-low pins and from a watchdog-overflow pulse into one pending register. It also holds a per-source mask register and a per-pin detection configuration. A host reaches all three registers through a plain synchronous read/write port. A single active-low output tells the host that at least one enabled source is pending.

The external pins are asynchronous, so each one passes through a two-flop synchronizer. After that it is detected either while it is low (level mode) or on a high-to-low transition (edge mode). The mode is chosen per pin.

Masking only hides a source. An event on a masked source is still latched and stays pending out of sight. It shows up, and pulls the interrupt output low, once its mask bit is cleared. A status read returns only the visible pending bits and clears exactly those.

Top module: `aux_irq_collect`

## Requirements
- R1: After reset the mask register reads all ones (value 0x07), the status and configuration registers read 0, and irq_n_o is high.
- R2: Mask bit value 0 enables a source and 1 disables it. A pending masked source reads as 0 in the status register and does not pull irq_n_o low.
- R3: With configuration bit i equal to 0 (level mode), pin i held low sets status bit i. The bit is set again on every cycle the pin stays low, so it reappears after a status read.
- R4: With configuration bit i equal to 1 (edge mode), one high-to-low transition of pin i sets status bit i once. A pin held low does not set the bit again after the bit is cleared by a read.
- R5: A read of the status register returns the pending bits that are unmasked and clears only those. Masked pending bits survive the read.
- R6: Clearing a mask bit makes a stored pending event of that source visible in the status register and drives irq_n_o low in the following cycle.
- R7: A one-cycle pulse on wdog_ovf_i sets status bit 2.
- R8: irq_n_o is low exactly while at least one pending bit has its mask bit at 0.
- R9: Writes to the status register have no effect. An event arriving in the same cycle as a status read is not lost; it reads as pending afterwards.
- R10: Register map: address 0 is status (read only), 1 is mask, 2 is configuration. Status and mask bits 0 and 1 are pins 0 and 1, and bit 2 is the watchdog. Configuration bits 0 and 1 select pins 0 and 1. Unused data bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n_i | input | 2 | Asynchronous active-low external request pins |
| wdog_ovf_i | input | 1 | Synchronous one-cycle watchdog overflow event |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears visible bits) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the addressed register |
| irq_n_o | output | 1 | Combined active-low interrupt |

## Verification
The bench hides events behind the mask and then unmasks them. A design that drops masked events, or that clears them on a status read, would never show them or raise the interrupt afterwards. It holds a pin low across a status read in both modes. A design with the modes swapped would lose the re-set in level mode, or keep re-raising the bit in edge mode. It also fires a watchdog pulse in the cycle of a status read and writes to the read-only status register. A clear that takes priority over a new set would lose that pulse, and a writable status register would change the bits it reads back.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_CFG    = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/aux_sync.sv
module aux_sync #(
    parameter int         W         = 2,
    parameter logic [0:0] RESET_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= {2*W{RESET_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stage2;
endmodule

// File: rtl/aux_detect.sv
module aux_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n_s,
    input  logic [N-1:0] edge_mode,
    output logic [N-1:0] evt_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } det_t;

    det_t d_d, d_q;

    always_comb begin
        d_d      = d_q;
        d_d.prev = pin_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.prev <= '1;
        end else begin
            d_q <= d_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        assign evt_o[i] = edge_mode[i] ? (d_q.prev[i] & ~pin_n_s[i]) : ~pin_n_s[i];

        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[i] && $past(edge_mode[i]) && evt_o[i]) |=> !evt_o[i]); // R4
    end
endmodule

// File: rtl/aux_irq_collect.sv
module aux_irq_collect
    import aux_irq_pkg::*;
#(
    parameter int N_PIN = 2,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIN-1:0]  pin_n_i,
    input  logic              wdog_ovf_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_n_o
);
    localparam int NSRC = N_PIN + 1;

    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic [NSRC-1:0]  mask;
        logic [N_PIN-1:0] cfg;
    } state_t;

    state_t st_d, st_q;

    logic [N_PIN-1:0] pin_s;
    logic [N_PIN-1:0] pin_evt;
    logic [NSRC-1:0]  evt_all;
    logic [NSRC-1:0]  visible;
    logic             rd_clr;
    logic             wr_mask;
    logic             wr_cfg;
    logic             unused_wdata;

    aux_sync #(.W(N_PIN), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_n_i),
        .sync_o  (pin_s)
    );

    aux_detect #(.N(N_PIN)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n_s   (pin_s),
        .edge_mode (st_q.cfg),
        .evt_o     (pin_evt)
    );

    assign evt_all      = {wdog_ovf_i, pin_evt};
    assign visible      = st_q.pend & ~st_q.mask;
    assign rd_clr       = reg_rd  && (reg_addr == REG_STATUS);
    assign wr_mask      = reg_wr  && (reg_addr == REG_MASK);
    assign wr_cfg       = reg_wr  && (reg_addr == REG_CFG);
    assign unused_wdata = ^reg_wdata[DW-1:NSRC];

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.pend = st_q.pend & st_q.mask;
        end
        st_d.pend = st_d.pend | evt_all;
        if (wr_mask) begin
            st_d.mask = reg_wdata[NSRC-1:0];
        end
        if (wr_cfg) begin
            st_d.cfg = reg_wdata[N_PIN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
            st_q.cfg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_STATUS: reg_rdata[NSRC-1:0]  = visible;
            REG_MASK:   reg_rdata[NSRC-1:0]  = st_q.mask;
            REG_CFG:    reg_rdata[N_PIN-1:0] = st_q.cfg;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_n_o = ~|visible;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            evt_all[i] |=> st_q.pend[i]); // R9

        AST_MASKED_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && st_q.mask[i] && st_q.pend[i]) |=> st_q.pend[i]); // R5

        AST_VISIBLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !st_q.mask[i] && st_q.pend[i] && !evt_all[i]) |=> !st_q.pend[i]); // R5
    end

    AST_UNMASK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && |(st_q.pend & ~reg_wdata[NSRC-1:0])) |=> !irq_n_o); // R6

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |-> irq_n_o); // R2
endmodule

// File: tb/sim_aux_irq_collect.sv
module sim_aux_irq_collect;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_n_i = 2'b11;
    logic       wdog_ovf_i = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_irq_collect u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n_i    (pin_n_i),
        .wdog_ovf_i (wdog_ovf_i),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_n_o    (irq_n_o)
    );

    // vector: [11:10] cfg, [9:8] pins driven low, [7] watchdog pulse,
    //         [6:4] mask, [3:1] expected status read, [0] expected irq_n
    localparam logic [11:0] VEC [6] = '{
        {2'b00, 2'b01, 1'b0, 3'b000, 3'b001, 1'b0},
        {2'b11, 2'b10, 1'b0, 3'b000, 3'b010, 1'b0},
        {2'b01, 2'b11, 1'b1, 3'b000, 3'b111, 1'b0},
        {2'b00, 2'b11, 1'b0, 3'b011, 3'b000, 1'b1},
        {2'b10, 2'b00, 1'b1, 3'b011, 3'b100, 1'b0},
        {2'b11, 2'b01, 1'b1, 3'b101, 3'b000, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic wd, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1; wdog_ovf_i = wd;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; wdog_ovf_i = 1'b0;
    endtask

    task automatic wd_pulse();
        @(negedge clk);
        wdog_ovf_i = 1'b1;
        @(negedge clk);
        wdog_ovf_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 irq_n", {7'd0, irq_n_o}, 8'h01);
        reg_read(2'd1, 1'b0, rv); check("R1 mask", rv, 8'h07);
        reg_read(2'd0, 1'b0, rv); check("R1 status", rv, 8'h00);
        reg_read(2'd2, 1'b0, rv); check("R1 cfg", rv, 8'h00);

        // vector table: R3 R4 R7 R8 R2
        for (int k = 0; k < 6; k++) begin
            logic [11:0] v;
            v = VEC[k];
            reg_write(2'd2, {6'd0, v[11:10]});
            reg_write(2'd1, {5'd0, v[6:4]});
            @(negedge clk);
            pin_n_i = ~v[9:8];
            wdog_ovf_i = v[7];
            @(negedge clk);
            wdog_ovf_i = 1'b0;
            idle(4);
            pin_n_i = 2'b11;
            idle(4);
            check("R8 vector irq_n", {7'd0, irq_n_o}, {7'd0, v[0]});
            reg_read(2'd0, 1'b0, rv);
            check("R2 R3 R4 R7 vector status", rv, {5'd0, v[3:1]});
            reg_write(2'd1, 8'h00);
            reg_read(2'd0, 1'b0, rv);
            reg_write(2'd1, 8'h07);
        end

        // R6 masked watchdog event revealed by unmask
        reg_write(2'd2, 8'h00);
        wd_pulse();
        idle(1);
        check("R2 masked irq_n", {7'd0, irq_n_o}, 8'h01);
        reg_read(2'd0, 1'b0, rv); check("R2 masked status", rv, 8'h00);
        reg_write(2'd1, 8'h03);
        check("R6 irq after unmask", {7'd0, irq_n_o}, 8'h00);
        reg_read(2'd0, 1'b0, rv); check("R6 status after unmask", rv, 8'h04);
        reg_read(2'd0, 1'b0, rv); check("R5 cleared by read", rv, 8'h00);
        check("R8 irq after clear", {7'd0, irq_n_o}, 8'h01);

        // R5 masked pin event survives a read
        reg_write(2'd2, 8'h01);
        reg_write(2'd1, 8'h07);
        @(negedge clk); pin_n_i = 2'b10;
        idle(4); pin_n_i = 2'b11; idle(3);
        reg_read(2'd0, 1'b0, rv); check("R5 masked read", rv, 8'h00);
        reg_write(2'd1, 8'h06);
        reg_read(2'd0, 1'b0, rv); check("R5 masked survived", rv, 8'h01);

        // R3 level mode re-sets while low
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h00);
        @(negedge clk); pin_n_i = 2'b10;
        idle(4);
        reg_read(2'd0, 1'b0, rv); check("R3 level first", rv, 8'h01);
        idle(1);
        check("R3 level irq again", {7'd0, irq_n_o}, 8'h00);
        reg_read(2'd0, 1'b0, rv); check("R3 level again", rv, 8'h01);
        pin_n_i = 2'b11; idle(4);
        reg_read(2'd0, 1'b0, rv);
        reg_read(2'd0, 1'b0, rv); check("R3 level released", rv, 8'h00);

        // R4 edge mode fires once while held low
        reg_write(2'd2, 8'h02);
        @(negedge clk); pin_n_i = 2'b01;
        idle(4);
        reg_read(2'd0, 1'b0, rv); check("R4 edge first", rv, 8'h02);
        idle(3);
        reg_read(2'd0, 1'b0, rv); check("R4 edge held", rv, 8'h00);
        check("R4 edge irq", {7'd0, irq_n_o}, 8'h01);
        pin_n_i = 2'b11; idle(3);

        // R9 status write ignored, event in read cycle kept
        wd_pulse();
        reg_write(2'd0, 8'h00);
        reg_read(2'd0, 1'b0, rv); check("R9 status write ignored", rv, 8'h04);
        reg_read(2'd0, 1'b1, rv); check("R9 read with event", rv, 8'h00);
        reg_read(2'd0, 1'b0, rv); check("R9 event kept", rv, 8'h04);

        // R10 unused bits read zero
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, 1'b0, rv); check("R10 cfg width", rv, 8'h03);
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, 1'b0, rv); check("R10 mask width", rv, 8'h07);
        reg_read(2'd3, 1'b0, rv); check("R10 unmapped", rv, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule